// File: doc/BRIEF.md
# Accumulator Character Output Serializer

The block drains a 24-bit accumulator as a stream of five-line characters aimed at a slow printing device. Each output command takes the four most significant accumulator bits into an extension latch and shifts the accumulator left by four, filling the low end with zeros. An odd parity bit is generated over those four bits. The resulting five bits, gated with a short timing strobe that lasts only while the command executes, form five output pulses.

A second stage catches the pulses in five character latches and holds them for a much longer period, so that a slow mechanism has time to read the character. A single counter measures that period. When the period ends, all five latches clear together. A command that arrives while a hold period is still running is reported as an overrun. It does not extend the hold period and does not disturb the held character.

The accumulator is loaded from a parallel input. Its contents stay visible at a port, so the shifting can be watched from outside.

Top module: `acc_char_out`

## Requirements
- R1: After reset the accumulator, strobe, pulses, character lines, busy and overrun are all zero.
- R2: An accepted command makes the accumulator equal to its previous value shifted left by four with zeros in bits [3:0], visible the cycle after the command.
- R3: Six commands empty a 24-bit accumulator. A seventh command outputs the character 5'b10000, which is nibble zero with parity one.
- R4: The character is {parity, nibble}. Nibble occupies lines [3:0], taken from accumulator bits [23:20]. Parity on line [4] is 1 exactly when the nibble holds an even number of ones, so the five bits always carry an odd number of ones.
- R5: The strobe is high for exactly STROBE_CYC cycles, starting the cycle after an accepted command. The pulses equal the character while the strobe is high and are zero otherwise.
- R6: A command raised while the strobe is high is ignored, and the accumulator does not shift.
- R7: From the second cycle after acceptance up to HOLD_CYC cycles after it, the character lines hold the character. After that, all of them are zero. Busy is high for the HOLD_CYC cycles that follow acceptance.
- R8: A line whose character bit is zero never goes high.
- R9: A command accepted while busy is high raises overrun for one cycle and still shifts the accumulator. It neither restarts the hold period nor changes the held lines.
- R10: Load writes load_data into the accumulator. In a cycle where a command is accepted, the command wins and the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Write load_data into the accumulator |
| load_data | input | ACC_W | Accumulator load value |
| out_cmd | input | 1 | Output command request |
| acc | output | ACC_W | Accumulator contents |
| strobe | output | 1 | Timing strobe of the executing command |
| pulses | output | NIB_W+1 | Character bits gated by the strobe |
| lines | output | NIB_W+1 | Stretched character latches |
| busy | output | 1 | Hold period running |
| overrun | output | 1 | One-cycle flag for a command during the hold period |

## Verification
The bench builds the block with STROBE_CYC=3 and HOLD_CYC=40. With these values a full hold period lasts about forty cycles, so every cycle of it can be checked for each character. The same 24-bit accumulator width is used. Three loads are chosen so that all sixteen nibble values pass through the parity and latch path, and the seventh command on an emptied accumulator is covered. The short strobe leaves plenty of hold time in which to inject an overrun, and lets a held-over command land squarely inside the strobe.

// File: rtl/acc_char_out.sv
module acc_char_out #(
  parameter int ACC_W      = 24,
  parameter int NIB_W      = 4,
  parameter int STROBE_CYC = 375000,
  parameter int HOLD_CYC   = 5000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] load_data,
  input  logic             out_cmd,
  output logic [ACC_W-1:0] acc,
  output logic             strobe,
  output logic [NIB_W:0]   pulses,
  output logic [NIB_W:0]   lines,
  output logic             busy,
  output logic             overrun
);
  localparam int SW = $clog2(STROBE_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [ACC_W-1:0] acc_q;
  logic [NIB_W-1:0] ext_q;
  logic             par_q;
  logic [SW-1:0]    stb_cnt;
  logic [HW-1:0]    hold_cnt;
  logic             own_q;
  logic [NIB_W:0]   lat_q;
  logic             ovr_q;

  wire              accept = out_cmd & ~strobe;
  wire [NIB_W-1:0]  top    = acc_q[ACC_W-1 -: NIB_W];
  wire [NIB_W:0]    char_w = {par_q, ext_q};

  assign acc     = acc_q;
  assign strobe  = stb_cnt != '0;
  assign busy    = hold_cnt != '0;
  assign pulses  = {(NIB_W+1){strobe}} & char_w;
  assign lines   = lat_q;
  assign overrun = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ext_q <= '0;
      par_q <= 1'b0;
    end else if (accept) begin
      acc_q <= {acc_q[ACC_W-NIB_W-1:0], {NIB_W{1'b0}}};
      ext_q <= top;
      par_q <= ~(^top);
    end else if (load) begin
      acc_q <= load_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      stb_cnt <= '0;
    else if (accept) stb_cnt <= SW'(STROBE_CYC);
    else if (strobe) stb_cnt <= stb_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      own_q    <= 1'b0;
      lat_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      ovr_q <= accept & busy;
      if (accept && !busy)    hold_cnt <= HW'(HOLD_CYC);
      else if (busy)          hold_cnt <= hold_cnt - 1'b1;
      if (accept && !busy)    own_q <= 1'b1;
      else if (stb_cnt == SW'(1)) own_q <= 1'b0;
      if (busy && hold_cnt == HW'(1)) lat_q <= '0;
      else if (strobe && own_q)       lat_q <= lat_q | pulses;
    end
  end
endmodule

// File: rtl/acc_char_out_chk.sv
module acc_char_out_chk #(
  parameter int ACC_W = 24,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] acc,
  input logic             strobe,
  input logic [NIB_W:0]   pulses,
  input logic [NIB_W:0]   lines,
  input logic             busy,
  input logic             overrun
);
  assert_pulses_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> pulses == '0);

  assert_lines_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lines == '0);

  assert_odd_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ^pulses);

  assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> acc[NIB_W-1:0] == '0);

  assert_overrun_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> busy);

  assert_overrun_holds_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && busy && $past(busy)) |-> $stable(lines));
endmodule

bind acc_char_out acc_char_out_chk #(.ACC_W(ACC_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .strobe(strobe), .pulses(pulses),
  .lines(lines), .busy(busy), .overrun(overrun)
);

// File: tb/tb_acc_char_out.sv
module tb_acc_char_out;
  localparam int S = 3;
  localparam int H = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [23:0] load_data = '0;
  logic        out_cmd = 1'b0;
  logic [23:0] acc;
  logic        strobe;
  logic [4:0]  pulses;
  logic [4:0]  lines;
  logic        busy;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_acc = '0;

  always #4 clk = ~clk;

  acc_char_out #(.ACC_W(24), .NIB_W(4), .STROBE_CYC(S), .HOLD_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .out_cmd(out_cmd), .acc(acc), .strobe(strobe), .pulses(pulses),
    .lines(lines), .busy(busy), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic odd_par(input logic [3:0] n);
    int c = 0;
    for (int b = 0; b < 4; b++) c += n[b];
    return (c % 2) == 0;
  endfunction

  task automatic do_load(input logic [23:0] v);
    @(negedge clk); load = 1'b1; load_data = v;
    @(negedge clk); load = 1'b0;
    exp_acc = v;
    check(acc == v, "R10 load", acc, v);
  endtask

  task automatic send(input bit hold2, input int ovr_at);
    logic [3:0] nib;
    logic [4:0] ch;
    logic [4:0] exp_l;
    nib = exp_acc[23:20];
    ch = {odd_par(nib), nib};
    exp_acc = exp_acc << 4;
    @(negedge clk); out_cmd = 1'b1;
    for (int i = 1; i <= H + 1; i++) begin
      @(negedge clk);
      if (i == 1 && !hold2) out_cmd = 1'b0;
      if (i == 2) out_cmd = 1'b0;
      if (i == 1) begin
        check(acc == exp_acc, "R2 shift", acc, exp_acc);
        check(overrun == 1'b0, "R9 no overrun", overrun, 0);
      end
      if (hold2 && i == 3)
        check(acc == exp_acc, "R6 ignored during strobe", acc, exp_acc);
      if (ovr_at != 0 && i == ovr_at) out_cmd = 1'b1;
      if (ovr_at != 0 && i == ovr_at + 1) begin
        out_cmd = 1'b0;
        exp_acc = exp_acc << 4;
        check(overrun == 1'b1, "R9 overrun flag", overrun, 1);
        check(acc == exp_acc, "R9 shift on overrun", acc, exp_acc);
      end
      if (ovr_at != 0 && i == ovr_at + 2)
        check(overrun == 1'b0, "R9 overrun one cycle", overrun, 0);
      if (ovr_at == 0 || i <= ovr_at) begin
        check(strobe == (i <= S), "R5 strobe width", strobe, i <= S);
        check(pulses == ((i <= S) ? ch : 5'd0), "R5 R4 pulses", pulses, (i <= S) ? ch : 5'd0);
      end
      exp_l = (i >= 2 && i <= H) ? ch : 5'd0;
      check(lines == exp_l, "R7 R8 lines", lines, exp_l);
      check(busy == (i <= H), "R7 busy", busy, i <= H);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(acc == 0 && lines == 0 && pulses == 0, "R1 reset data", {acc, 3'b0, lines}, 0);
    check(!busy && !strobe && !overrun, "R1 reset flags", {busy, strobe, overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_load(24'h012345);
    for (int k = 0; k < 6; k++) send(1'b0, 0);
    check(acc == 24'h0, "R3 empty after six", acc, 0);
    send(1'b0, 0);
    check(acc == 24'h0, "R3 seventh stays empty", acc, 0);
    do_load(24'h6789AB);
    for (int k = 0; k < 6; k++) send(1'b0, 0);
    do_load(24'hCDEF00);
    for (int k = 0; k < 4; k++) send(1'b0, 0);
    do_load(24'hA50000);
    send(1'b1, 0);
    check(acc == 24'h500000, "R6 single shift", acc, 24'h500000);
    do_load(24'h3C1000);
    send(1'b0, 10);
    check(acc == 24'h100000, "R9 acc after overrun", acc, 24'h100000);
    @(negedge clk);
    exp_acc = acc;
    load = 1'b1; load_data = 24'hFFFFFF; out_cmd = 1'b1;
    @(negedge clk);
    load = 1'b0; out_cmd = 1'b0;
    check(acc == 24'h000000, "R10 command beats load", acc, 0);
    repeat (H + 2) @(negedge clk);
    check(lines == 0 && !busy, "R7 idle after hold", {busy, lines}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule